// File: doc/BRIEF.md
# Free-Running Counter with Coherent Snapshot

The block keeps a 64-bit counter that advances by one on every clock and never stops. Software on a 32-bit register bus cannot read such a counter in one access. Two reads of a moving value could also tear across a carry from the low half into the high half. The block avoids this with a pair of 32-bit snapshot words. A single command copies the whole counter into both words in one cycle, so the two later reads always belong together.

The bus is a simple single-cycle register port. A write takes effect on the clock edge where `bus_wr` is high, and the read data is a combinational decode of `bus_addr`. The snapshot words sit at address 0 (counter bits 31:0) and address 1 (counter bits 63:32), and the command/control word sits at address 2. Software may also write either snapshot word directly. A command write can capture the counter, zero the snapshot, or do both. The command bits clear themselves, and the other control bits are kept as plain storage.

Top module: `cnt_snapshot`

## Requirements
- R1: After reset the free-running counter is zero. It then advances by exactly one on every clock edge where `rst_n` is high.
- R2: A write to address 0 or address 1 loads that snapshot word with `bus_wdata`. A read of the same address returns the value, and the other snapshot word is unchanged.
- R3: A write to address 2 with bit 1 set and bit 0 clear captures the counter value present in the write cycle. Counter bits 31:0 go to address 0 and bits 63:32 go to address 1, and both are readable from the next cycle.
- R4: A write to address 2 with bit 0 set zeroes both snapshot words.
- R5: A write to address 2 with bits 1 and 0 both set leaves both snapshot words at zero, because the clear wins over the capture.
- R6: A read of address 2 returns the last written control value with bits 1:0 forced to zero. Bits 31:2 are stored exactly as written.
- R7: While `rst_n` is low at a clock edge, both snapshot words and the control word become zero.
- R8: The clear command does not touch the free-running counter. A capture taken after a clear returns the uninterrupted count.
- R9: Address 3 reads as zero. A write to address 3 changes no register.
- R10: A write to address 2 with bits 1:0 both zero leaves both snapshot words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address (0 low word, 1 high word, 2 control) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational decode of `bus_addr` |

## Verification
Every register result is due one clock edge after the write that causes it. Read data follows the address with no delay. The bench therefore drives each write on a falling edge and lets exactly one rising edge pass. It then changes the address on the next falling edge and samples a nanosecond later, well away from any rising edge. For a capture, the expected value is the bench's own cycle count at the moment the write is driven. That count is zeroed under reset and advanced on each rising edge, so it matches the counter value the block sees at the capturing edge.

// File: rtl/cs_pkg.sv
// Package: shared constants for the counter snapshot block.
// Assumes the control word sits directly above the snapshot words.
package cs_pkg;
    localparam int CMD_CLEAR_BIT = 0;   // zero the snapshot
    localparam int CMD_LATCH_BIT = 1;   // capture the counter
    localparam int CMD_BITS      = 2;   // self-clearing field width
endpackage

// File: rtl/cs_free_counter.sv
// Module: cs_free_counter
// Free-running up counter. It wraps at 2**WIDTH and has no load or clear input.
// Assumes rst_n is synchronous and active low.
module cs_free_counter #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] count
);
    // Advance by one every clock, zero under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    // R1
    property count_step_chk_p;
        @(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (count == $past(count) + 1'b1);
    endproperty
    count_step_chk: assert property (count_step_chk_p);
endmodule

// File: rtl/cs_snap_word.sv
// Module: cs_snap_word
// One bus-width slice of the snapshot. Clear has priority over capture,
// and capture has priority over a direct write. The caller guarantees
// that a direct write and a command never target this word in the same cycle.
module cs_snap_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         lat_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] q
);
    // Update the held word from clear, capture or direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clr_i) q <= '0;
        else if (lat_i) q <= src_i;
        else if (wr_i)  q <= wdata_i;
    end

    // R3
    property latch_copy_chk_p;
        @(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(lat_i) && !$past(clr_i)) |-> (q == $past(src_i));
    endproperty
    latch_copy_chk: assert property (latch_copy_chk_p);

    // R4
    property clear_zero_chk_p;
        @(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(clr_i)) |-> (q == '0);
    endproperty
    clear_zero_chk: assert property (clear_zero_chk_p);

    // R2
    property direct_wr_chk_p;
        @(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(wr_i) && !$past(clr_i) && !$past(lat_i))
                |-> (q == $past(wdata_i));
    endproperty
    direct_wr_chk: assert property (direct_wr_chk_p);

    // R10
    property hold_chk_p;
        @(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(wr_i) && !$past(clr_i) && !$past(lat_i))
                |-> $stable(q);
    endproperty
    hold_chk: assert property (hold_chk_p);
endmodule

// File: rtl/cnt_snapshot.sv
// Module: cnt_snapshot (top)
// Free-running counter with a coherent multi-word snapshot on a register bus.
// Snapshot word i sits at address i, and the control word sits at address NWORDS.
// Assumes CNT_W is a multiple of BUS_W and that NWORDS+1 addresses fit in ADDR_W bits.
module cnt_snapshot #(
    parameter int CNT_W  = 64,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    import cs_pkg::*;

    localparam int NWORDS = CNT_W / BUS_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NWORDS);

    logic [CNT_W-1:0] count;
    logic [BUS_W-1:0] snap [NWORDS];
    logic [BUS_W-1:0] ctrl_q;
    logic             ctrl_wr;
    logic             do_clear;
    logic             do_latch;

    cs_free_counter #(.WIDTH(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    // Decode a command write into its two one-cycle actions.
    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
        do_clear = ctrl_wr && bus_wdata[CMD_CLEAR_BIT];
        do_latch = ctrl_wr && bus_wdata[CMD_LATCH_BIT];
    end

    // Store the control word, with the self-clearing command bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= {bus_wdata[BUS_W-1:CMD_BITS], {CMD_BITS{1'b0}}};
    end

    genvar gi;
    generate
        for (gi = 0; gi < NWORDS; gi++) begin : g_word
            cs_snap_word #(.W(BUS_W)) u_word (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (do_clear),
                .lat_i   (do_latch),
                .wr_i    (bus_wr && (bus_addr == ADDR_W'(gi))),
                .wdata_i (bus_wdata),
                .src_i   (count[gi*BUS_W +: BUS_W]),
                .q       (snap[gi])
            );
        end
    endgenerate

    // Read decode: snapshot words, then control, and zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NWORDS; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = snap[i];
        if (bus_addr == CTRL_ADDR) bus_rdata = ctrl_q;
    end

    // R6
    property ctrl_store_chk_p;
        @(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ctrl_wr))
                |-> (ctrl_q[BUS_W-1:CMD_BITS] == $past(bus_wdata[BUS_W-1:CMD_BITS])
                     && ctrl_q[CMD_BITS-1:0] == '0);
    endproperty
    ctrl_store_chk: assert property (ctrl_store_chk_p);

    // R7
    property reset_zero_chk_p;
        @(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (ctrl_q == '0 && snap[0] == '0 && count == '0);
    endproperty
    reset_zero_chk: assert property (reset_zero_chk_p);

    // R9
    property hole_read_chk_p;
        @(posedge clk) disable iff (!rst_n)
            (bus_addr > CTRL_ADDR) |-> (bus_rdata == '0);
    endproperty
    hole_read_chk: assert property (hole_read_chk_p);
endmodule

// File: tb/tb_cnt_snapshot.sv
// Bench for cnt_snapshot: a vector table walk, then directed reset and corner tests.
module tb_cnt_snapshot;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad   = 0;
    logic [63:0] mcnt = 64'd0;   // bench cycle count, zero under reset
    logic [63:0] cap;

    always #5 clk = ~clk;

    always @(posedge clk) mcnt <= rst_n ? mcnt + 64'd1 : 64'd0;

    cnt_snapshot dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // kind: 0 constant, 1 captured low word, 2 captured high word
    typedef struct packed {
        logic [1:0]  waddr;
        logic [31:0] wdata;
        logic [1:0]  raddr;
        logic [1:0]  kind;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'hA5A5_0001, 2'd0, 2'd0, 32'hA5A5_0001, 4'd2},  // R2 low
        '{2'd1, 32'hDEAD_BEEF, 2'd1, 2'd0, 32'hDEAD_BEEF, 4'd2},  // R2 high
        '{2'd0, 32'h0000_1234, 2'd1, 2'd0, 32'hDEAD_BEEF, 4'd2},  // R2 other word kept
        '{2'd2, 32'h0000_00F0, 2'd0, 2'd0, 32'h0000_1234, 4'd10}, // R10 no command
        '{2'd2, 32'hABCD_0070, 2'd2, 2'd0, 32'hABCD_0070, 4'd6},  // R6 stored
        '{2'd2, 32'h0000_0102, 2'd0, 2'd1, 32'h0,         4'd3},  // R3 capture low
        '{2'd2, 32'h0000_0002, 2'd1, 2'd2, 32'h0,         4'd3},  // R3 capture high
        '{2'd2, 32'h0000_0001, 2'd0, 2'd0, 32'h0,         4'd4},  // R4 clear low
        '{2'd1, 32'h0000_5555, 2'd1, 2'd0, 32'h0000_5555, 4'd2},  // R2 refill
        '{2'd2, 32'h0000_0003, 2'd1, 2'd0, 32'h0,         4'd5},  // R5 both set
        '{2'd2, 32'h0000_0003, 2'd2, 2'd0, 32'h0,         4'd6},  // R6 cmd bits read 0
        '{2'd2, 32'hFFFF_FFFF, 2'd2, 2'd0, 32'hFFFF_FFFC, 4'd6},  // R6 all ones
        '{2'd3, 32'h0000_0077, 2'd3, 2'd0, 32'h0,         4'd9},  // R9 hole reads 0
        '{2'd3, 32'hFFFF_FFFF, 2'd2, 2'd0, 32'hFFFF_FFFC, 4'd9}   // R9 write ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive one write on a falling edge and record the count it sees.
    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cap = mcnt;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_at(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] c1;
        do_reset();
        // R7 state straight after reset
        read_at(2'd0, v); check("R7 low", v, 32'h0);
        read_at(2'd1, v); check("R7 high", v, 32'h0);
        read_at(2'd2, v); check("R7 ctrl", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] e;
            string tag;
            do_write(VEC[i].waddr, VEC[i].wdata);
            read_at(VEC[i].raddr, v);
            case (VEC[i].kind)
                2'd1:    e = cap[31:0];
                2'd2:    e = cap[63:32];
                default: e = VEC[i].expv;
            endcase
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            check(tag, v, e);
        end

        // R1: two captures a known number of cycles apart
        do_write(2'd2, 32'h2); c1 = cap;
        read_at(2'd0, v); check("R1 first", v, c1[31:0]);
        repeat (17) @(negedge clk);
        do_write(2'd2, 32'h2);
        read_at(2'd0, v); check("R1 step", v - c1[31:0], 32'd19);

        // R8: the clear leaves the counter running
        do_write(2'd2, 32'h1);
        read_at(2'd0, v); check("R8 cleared", v, 32'h0);
        repeat (5) @(negedge clk);
        do_write(2'd2, 32'h2);
        read_at(2'd0, v); check("R8 count kept", v, cap[31:0]);
        read_at(2'd1, v); check("R8 high", v, cap[63:32]);

        // R7: reset mid-run clears all the stored words
        do_write(2'd0, 32'h1111_2222);
        do_write(2'd1, 32'h3333_4444);
        do_write(2'd2, 32'hCAFE_0000);
        do_reset();
        read_at(2'd0, v); check("R7 low again", v, 32'h0);
        read_at(2'd1, v); check("R7 high again", v, 32'h0);
        read_at(2'd2, v); check("R7 ctrl again", v, 32'h0);
        // R1: counter restarts from zero
        do_write(2'd2, 32'h2);
        read_at(2'd0, v); check("R1 restart", v, cap[31:0]);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule